// File: doc/BRIEF.md
# Scrolling Seven-Segment Command Register Bank

This block sits behind a serial-peripheral slave that has already turned the wire traffic into whole bytes. It reads those bytes as two-byte commands. The first byte of a command carries the direction and a register address. The second byte carries the data. Through these commands a host writes and reads a small bank of 8-bit registers. The bank holds eight character buffers, a digit enable mask, a refresh value for the display driver, a control register and a status register.

Four consecutive buffers are shown on the four visible digits at any time. The window starts at a 3-bit offset and wraps modulo 8. With motion switched on, the offset advances by one after every `STEP_TICKS` refresh ticks, so the text scrolls left. Each time the offset wraps from 7 back to 0, a pending flag is set, and an interrupt can be raised from it. While the host's side of the text is hidden, the host refills the four hidden buffers, so strings of any length can run across the panel.

Top module: `segscr_top`

## Requirements
- R1: During and after a synchronous reset, every register, the digit outputs, the read byte and the interrupt are zero, and the byte phase is the opcode phase.
- R2: A command is an opcode byte and then a data byte. In the opcode byte, bit 7 set means write, bit 7 clear means read, and bits 3:0 are the address. A written register shows its new value at the ports two clock edges after the edge that accepts the data byte.
- R3: After a read opcode is accepted, `rd_byte` carries the addressed register two edges later and holds it until the next read. Addresses 0..7 are the buffers, 8 is the mask, 9 is the refresh value, 10 is control (bit 0 motion, bit 1 interrupt enable, other bits read 0), 11 is status (bit 0 pending, other bits read 0), and 12..15 read as 0.
- R4: While `sel_n` is high, the byte phase returns to opcode and any byte that arrives is ignored. A command cut short by `sel_n` writes nothing.
- R5: Writes to addresses 12..15 change no register.
- R6: `digit_en` and `refresh_val` follow the mask and refresh registers.
- R7: Digit d (bits 8d+7:8d of `digits`) shows buffer (offset+d) mod 8. It is updated one edge after a buffer or the offset changes.
- R8: With motion on, the offset advances by one after every `STEP_TICKS` accepted ticks. With motion off, the offset is frozen and the tick count restarts from zero.
- R9: When the offset wraps from 7 to 0, status bit 0 is set one edge later. `irq` is high one edge after status bit 0 and interrupt enable are both set.
- R10: Writing a data byte with bit 0 set to address 11 clears the pending bit. A rollover in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select from the serial slave, active low |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| refresh_tick | input | 1 | One-cycle pulse per refresh step |
| digits | output | 32 | Four visible characters, digit 0 in the low byte |
| digit_en | output | 8 | Digit enable mask register |
| refresh_val | output | 8 | Refresh value register |
| irq | output | 1 | Rollover interrupt |
| rd_byte | output | 8 | Read-back byte for the serial slave |

## Verification
Each result has its own latency. A write lands at the ports two edges after its data byte, and a read lands two edges after its opcode. The digits follow a buffer or offset change by one edge. Status follows a wrap by one edge and the interrupt follows status by one more. The bench reference model applies those exact delays to its own arrays at each rising edge and compares every output at the falling edge, so a result that comes one cycle early or late is reported. The directed checks with literal values are taken only after the stimulus has gone quiet for longer than the deepest of these latencies.

// File: rtl/segscr_pkg.sv
package segscr_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_BUF = 8;
  localparam int NUM_DIG = 4;
  localparam int ADDR_W  = 4;
  localparam int OFF_W   = $clog2(NUM_BUF);

  localparam logic [ADDR_W-1:0] A_MASK = 4'd8;
  localparam logic [ADDR_W-1:0] A_RATE = 4'd9;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd10;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd11;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/segscr_cmd_dec.sv
module segscr_cmd_dec
  import segscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output wr_cmd_t           wr_o,
  output logic              rd_vld_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic              data_ph;
  logic              op_wr;
  logic [ADDR_W-1:0] op_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ph   <= 1'b0;
      op_wr     <= 1'b0;
      op_addr   <= '0;
      wr_o      <= '0;
      rd_vld_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_o.vld <= 1'b0;
      rd_vld_o <= 1'b0;
      if (sel_n) begin
        data_ph <= 1'b0;
      end else if (rx_valid) begin
        if (!data_ph) begin
          data_ph   <= 1'b1;
          op_wr     <= rx_byte[BYTE_W-1];
          op_addr   <= rx_byte[ADDR_W-1:0];
          rd_vld_o  <= ~rx_byte[BYTE_W-1];
          rd_addr_o <= rx_byte[ADDR_W-1:0];
        end else begin
          data_ph   <= 1'b0;
          wr_o.vld  <= op_wr;
          wr_o.addr <= op_addr;
          wr_o.data <= rx_byte;
        end
      end
    end
  end

  // R4: a deselected cycle leaves the decoder in opcode phase
  a_r4_sel_resets_phase: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !data_ph);
  // R2: a write strobe only follows an accepted byte
  a_r2_write_after_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_o.vld) |-> $past(rx_valid && !sel_n));
  // R3: a read request only follows an accepted byte
  a_r3_read_after_byte: assert property (@(posedge clk) disable iff (rst)
    rd_vld_o |-> $past(rx_valid && !sel_n));
endmodule

// File: rtl/segscr_scroll.sv
module segscr_scroll
  import segscr_pkg::*;
#(
  parameter int STEP_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             motion_en,
  output logic [OFF_W-1:0] off_o,
  output logic             roll_o
);
  localparam int CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_TICKS - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(NUM_BUF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      off_o  <= '0;
      roll_o <= 1'b0;
    end else begin
      roll_o <= 1'b0;
      if (!motion_en) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CNT_LAST) begin
          cnt    <= '0;
          off_o  <= off_o + 1'b1;
          roll_o <= (off_o == OFF_LAST);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: the offset only moves on a tick while motion is on
  a_r8_move_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (off_o != $past(off_o)) |-> $past(tick && motion_en));
  // R8: the offset moves by exactly one position
  a_r8_step_of_one: assert property (@(posedge clk) disable iff (rst)
    (off_o != $past(off_o)) |-> (off_o == $past(off_o) + 1'b1));
  // R9: a rollover pulse coincides with the wrap to zero
  a_r9_roll_at_zero: assert property (@(posedge clk) disable iff (rst)
    roll_o |-> (off_o == '0));
endmodule

// File: rtl/segscr_regs.sv
module segscr_regs
  import segscr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  wr_cmd_t                   wr_i,
  input  logic                      roll_i,
  output logic [NUM_BUF*BYTE_W-1:0] bufs_o,
  output logic [BYTE_W-1:0]         mask_o,
  output logic [BYTE_W-1:0]         rate_o,
  output logic [1:0]                ctrl_o,
  output logic                      stat_o
);
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)
        bufs_o[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_i.vld && wr_i.addr == ADDR_W'(b))
        bufs_o[b*BYTE_W +: BYTE_W] <= wr_i.data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      rate_o <= '0;
      ctrl_o <= '0;
      stat_o <= 1'b0;
    end else begin
      if (wr_i.vld) begin
        unique case (wr_i.addr)
          A_MASK:  mask_o <= wr_i.data;
          A_RATE:  rate_o <= wr_i.data;
          A_CTRL:  ctrl_o <= wr_i.data[1:0];
          default: ;
        endcase
      end
      if (roll_i)
        stat_o <= 1'b1;
      else if (wr_i.vld && wr_i.addr == A_STAT && wr_i.data[0])
        stat_o <= 1'b0;
    end
  end

  // R9: pending only rises after a rollover
  a_r9_stat_from_roll: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o) |-> $past(roll_i));
  // R10: pending only falls after a clear write
  a_r10_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_o) |-> $past(wr_i.vld && wr_i.addr == A_STAT && wr_i.data[0]));
endmodule

// File: rtl/segscr_top.sv
module segscr_top
  import segscr_pkg::*;
#(
  parameter int STEP_TICKS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel_n,
  input  logic                      rx_valid,
  input  logic [BYTE_W-1:0]         rx_byte,
  input  logic                      refresh_tick,
  output logic [NUM_DIG*BYTE_W-1:0] digits,
  output logic [BYTE_W-1:0]         digit_en,
  output logic [BYTE_W-1:0]         refresh_val,
  output logic                      irq,
  output logic [BYTE_W-1:0]         rd_byte
);
  wr_cmd_t                   wr_cmd;
  logic                      rd_vld;
  logic [ADDR_W-1:0]         rd_addr;
  logic [NUM_BUF*BYTE_W-1:0] bufs;
  logic [1:0]                ctrl;
  logic                      stat;
  logic [OFF_W-1:0]          off;
  logic                      roll;

  segscr_cmd_dec u_dec (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_o(wr_cmd), .rd_vld_o(rd_vld), .rd_addr_o(rd_addr)
  );

  segscr_regs u_regs (
    .clk(clk), .rst(rst), .wr_i(wr_cmd), .roll_i(roll), .bufs_o(bufs),
    .mask_o(digit_en), .rate_o(refresh_val), .ctrl_o(ctrl), .stat_o(stat)
  );

  segscr_scroll #(.STEP_TICKS(STEP_TICKS)) u_scroll (
    .clk(clk), .rst(rst), .tick(refresh_tick), .motion_en(ctrl[0]),
    .off_o(off), .roll_o(roll)
  );

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
    logic [OFF_W-1:0] idx;
    assign idx = off + OFF_W'(d);
    always_ff @(posedge clk) begin
      if (rst) digits[d*BYTE_W +: BYTE_W] <= '0;
      else     digits[d*BYTE_W +: BYTE_W] <= bufs[idx*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= stat & ctrl[1];
      if (rd_vld) begin
        if (rd_addr < ADDR_W'(NUM_BUF)) begin
          rd_byte <= bufs[rd_addr[OFF_W-1:0]*BYTE_W +: BYTE_W];
        end else begin
          unique case (rd_addr)
            A_MASK:  rd_byte <= digit_en;
            A_RATE:  rd_byte <= refresh_val;
            A_CTRL:  rd_byte <= {{(BYTE_W-2){1'b0}}, ctrl};
            A_STAT:  rd_byte <= {{(BYTE_W-1){1'b0}}, stat};
            default: rd_byte <= '0;
          endcase
        end
      end
    end
  end

  // R9: the interrupt follows pending and enable by one edge
  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(stat && ctrl[1]));
  // R3: the read byte only changes after a read request
  a_r3_rd_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_vld) |-> $stable(rd_byte));
endmodule

// File: tb/tb_segscr_top.sv
module tb_segscr_top;
  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        refresh_tick = 1'b0;
  logic [31:0] digits;
  logic [7:0]  digit_en, refresh_val, rd_byte;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  segscr_top #(.STEP_TICKS(STEP)) dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .refresh_tick(refresh_tick), .digits(digits), .digit_en(digit_en),
    .refresh_val(refresh_val), .irq(irq), .rd_byte(rd_byte)
  );

  // Behavioural reference model
  int m_buf[8];
  int m_mask, m_rate, m_ctrl, m_stat, m_off, m_cnt;
  int m_phase, m_opdir, m_opaddr;
  int p_wr, p_waddr, p_wdata, p_rd, p_raddr, p_roll;
  int e_dig[4];
  int e_irq, e_rd;

  function automatic int reg_val(int a);
    if (a < 8) return m_buf[a];
    case (a)
      8: return m_mask;
      9: return m_rate;
      10: return m_ctrl;
      11: return m_stat;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_buf[i]) m_buf[i] = 0;
      foreach (e_dig[i]) e_dig[i] = 0;
      m_mask = 0; m_rate = 0; m_ctrl = 0; m_stat = 0; m_off = 0; m_cnt = 0;
      m_phase = 0; m_opdir = 0; m_opaddr = 0;
      p_wr = 0; p_waddr = 0; p_wdata = 0; p_rd = 0; p_raddr = 0; p_roll = 0;
      e_irq = 0; e_rd = 0;
    end else begin
      int o_buf[8];
      int o_off, o_ctrl, o_stat, n_roll;
      o_buf = m_buf; o_off = m_off; o_ctrl = m_ctrl; o_stat = m_stat;
      if (p_rd) e_rd = reg_val(p_raddr);
      e_irq = ((o_stat & (o_ctrl >> 1)) & 1);
      for (int d = 0; d < 4; d++) e_dig[d] = o_buf[(o_off + d) % 8];
      if (p_wr) begin
        if (p_waddr < 8) m_buf[p_waddr] = p_wdata;
        else if (p_waddr == 8) m_mask = p_wdata;
        else if (p_waddr == 9) m_rate = p_wdata;
        else if (p_waddr == 10) m_ctrl = p_wdata & 3;
      end
      if (p_roll) m_stat = 1;
      else if (p_wr && p_waddr == 11 && (p_wdata & 1)) m_stat = 0;
      n_roll = 0;
      if ((o_ctrl & 1) == 0) m_cnt = 0;
      else if (refresh_tick) begin
        if (m_cnt == STEP - 1) begin
          m_cnt = 0;
          n_roll = (o_off == 7);
          m_off = (o_off + 1) % 8;
        end else m_cnt = m_cnt + 1;
      end
      p_roll = n_roll;
      p_wr = 0; p_rd = 0;
      if (sel_n) m_phase = 0;
      else if (rx_valid) begin
        if (m_phase == 0) begin
          m_phase = 1; m_opdir = rx_byte[7]; m_opaddr = rx_byte[3:0];
          p_rd = !rx_byte[7]; p_raddr = rx_byte[3:0];
        end else begin
          m_phase = 0; p_wr = m_opdir; p_waddr = m_opaddr; p_wdata = rx_byte;
        end
      end
    end
  end

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      bit bad;
      bad = 0;
      tests++;
      for (int d = 0; d < 4; d++)
        if (digits[d*8 +: 8] != 8'(e_dig[d])) begin
          bad = 1;
          $display("FAIL R7 model digit %0d: got %h exp %h", d, digits[d*8 +: 8], e_dig[d]);
        end
      if (digit_en != 8'(m_mask) || refresh_val != 8'(m_rate)) begin
        bad = 1;
        $display("FAIL R6 model mask/rate: got %h/%h exp %h/%h", digit_en, refresh_val, m_mask, m_rate);
      end
      if (irq != 1'(e_irq)) begin
        bad = 1;
        $display("FAIL R9 model irq: got %0d exp %0d", irq, e_irq);
      end
      if (rd_byte != 8'(e_rd)) begin
        bad = 1;
        $display("FAIL R3 model rd_byte: got %h exp %h", rd_byte, e_rd);
      end
      if (bad) fails++;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] data);
    @(negedge clk); sel_n = 1'b0;
    send_byte(op);
    send_byte(data);
    @(negedge clk); sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(int a, int v); cmd(8'h80 | 8'(a), 8'(v)); endtask
  task automatic rd(int a);        cmd(8'(a), 8'h00);           endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refresh_tick = 1'b1;
      @(negedge clk); refresh_tick = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    // R1 reset values
    check("R1 digits", digits, 32'h0);
    check("R1 irq/rd", {23'd0, irq, rd_byte}, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R7 buffer writes reach the digits
    for (int i = 0; i < 8; i++) wr(i, 8'h10 + i);
    check("R7 window at offset 0", digits, 32'h13121110);
    // R6 mask and refresh
    wr(8, 8'h0F); wr(9, 8'h55);
    check("R6 digit_en", {24'd0, digit_en}, 32'h0F);
    check("R6 refresh_val", {24'd0, refresh_val}, 32'h55);
    // R3 read-back with field masking
    rd(2);  check("R3 read buffer 2", {24'd0, rd_byte}, 32'h12);
    wr(10, 8'hFE);
    rd(10); check("R3 control reads bits 1:0", {24'd0, rd_byte}, 32'h02);
    wr(10, 8'h00);
    // R5 undefined address writes are ignored
    wr(12, 8'hAA);
    rd(12); check("R5 undefined address reads 0", {24'd0, rd_byte}, 32'h0);
    rd(8);  check("R5 mask untouched", {24'd0, rd_byte}, 32'h0F);
    check("R5 digits untouched", digits, 32'h13121110);
    // R4 aborted command and deselected byte
    @(negedge clk); sel_n = 1'b0;
    send_byte(8'h89);
    @(negedge clk); sel_n = 1'b1;
    send_byte(8'h77);
    @(negedge clk); sel_n = 1'b0;
    send_byte(8'h09);
    send_byte(8'h00);
    @(negedge clk); sel_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 aborted write leaves refresh", {24'd0, refresh_val}, 32'h55);
    check("R4 fresh opcode read", {24'd0, rd_byte}, 32'h55);

    // R8 motion: STEP ticks advance by one
    wr(10, 8'h03);
    ticks(STEP);
    check("R8 one step", digits, 32'h14131211);
    wr(10, 8'h02);
    ticks(2 * STEP);
    check("R8 frozen while motion off", digits, 32'h14131211);
    wr(5, 8'h25);
    check("R7 staged rewrite visible", digits, 32'h14131211);
    wr(10, 8'h03);
    ticks(STEP * 7);
    // R9 wrap sets pending and raises irq
    check("R9 back at offset 0", digits, 32'h13121110);
    check("R9 irq high", {31'd0, irq}, 32'h1);
    rd(11); check("R9 pending read", {24'd0, rd_byte}, 32'h01);
    // R10 clear pending
    wr(11, 8'h01);
    check("R10 irq cleared", {31'd0, irq}, 32'h0);
    rd(11); check("R10 pending cleared", {24'd0, rd_byte}, 32'h0);
    // R9 interrupt enable off: pending set, irq low
    wr(10, 8'h01);
    ticks(STEP * 8);
    check("R9 irq masked", {31'd0, irq}, 32'h0);
    rd(11); check("R9 pending without enable", {24'd0, rd_byte}, 32'h01);
    check("R8 full cycle returns", digits, 32'h13121110);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule